// File: doc/BRIEF.md
# Shared-Chain Multifunction ALU

This block is a purely combinational N-bit arithmetic logic unit. Every operation it offers is obtained by steering one ripple-carry adder datapath, not by selecting among separate function units. An operand-preparation stage chooses what is fed to the two adder inputs and the chain's carry-in. The same stage also decides whether the inter-bit carries are suppressed. With carries suppressed, the adder's per-bit propagate term gives exclusive-OR and its per-bit generate term gives AND.

Subtraction works by inverting one operand and forcing the carry-in high. The left shift adds an operand to itself. The complement of A adds the inverted operand to zero with carries suppressed. The unit takes two operands, a carry-in and a 3-bit opcode. It returns an N-bit result and a carry-out. The result settles within the same evaluation as its inputs, with no clock and no internal state.

There is no state machine. Each opcode selects a static configuration of the chain, and all of these configurations are listed in the requirements below.

Top module: `shared_chain_alu`

## Requirements
- R1: Opcode 3'b000 (add) gives {carry_out, result} = op_a + op_b + carry_in, computed to N+1 bits.
- R2: Opcode 3'b001 (subtract) gives result = op_b - op_a modulo 2^N. carry_out is 1 exactly when op_b >= op_a (unsigned). carry_in has no effect.
- R3: Opcode 3'b010 (exclusive-OR) gives result = op_a ^ op_b and carry_out = 0.
- R4: Opcode 3'b011 (AND) gives result = op_a & op_b and carry_out = 0.
- R5: Opcode 3'b100 (complement) gives result = ~op_a and carry_out = 0. op_b and carry_in have no effect.
- R6: Opcode 3'b101 (shift left) gives result = op_b << 1 with bit 0 equal to 0, and carry_out = op_b[N-1]. op_a and carry_in have no effect.
- R7: Opcodes 3'b110 and 3'b111 give result = 0 and carry_out = 0 for any operands.
- R8: For the three logic opcodes (3'b010, 3'b011, 3'b100), no carry crosses between bits and carry_in has no effect. For example, exclusive-OR of two all-ones operands with carry_in = 1 gives all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | External carry into bit 0, used by add only |
| opcode | input | 3 | Operation select |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry out of the top bit for add, subtract and shift; otherwise 0 |

## Verification
The bench goes after the carry paths at their extremes. Adding all ones with carry_in = 1 exercises a full-length ripple, so a chain that dropped or misrouted a carry would give a wrong top bit or a wrong carry_out. For the logic opcodes the bench uses all-ones operands with carry_in = 1, so a chain whose carry suppression leaked would corrupt the exclusive-OR, AND or complement result, or raise carry_out. For subtraction the bench covers the equal-operand and borrow cases, where a wrong inversion or a wrong forced carry-in would be off by one or would flip carry_out. The bench also sets bit N-1 of op_b for the shift and drives both reserved codes with busy operands; an incomplete opcode decode would show up as a nonzero reserved result or a shift that loses its top bit.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OPW = 3;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_XOR  = 3'd2,
        OP_AND  = 3'd3,
        OP_NOTA = 3'd4,
        OP_SHL  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

endpackage

// File: rtl/operand_prep.sv
module operand_prep
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] add_x,
    output logic [WIDTH-1:0] add_y,
    output logic             chain_cin,
    output logic             kill_carry,
    output logic             pick_gen,
    output logic             force_zero
);

    localparam logic [WIDTH-1:0] ZERO_W = '0;

    always_comb begin
        add_x      = ZERO_W;
        add_y      = ZERO_W;
        chain_cin  = 1'b0;
        kill_carry = 1'b1;
        pick_gen   = 1'b0;
        force_zero = 1'b0;
        unique case (op)
            OP_ADD: begin
                add_x      = op_a;
                add_y      = op_b;
                chain_cin  = carry_in;
                kill_carry = 1'b0;
            end
            OP_SUB: begin
                add_x      = ~op_a;
                add_y      = op_b;
                chain_cin  = 1'b1;
                kill_carry = 1'b0;
            end
            OP_XOR: begin
                add_x = op_a;
                add_y = op_b;
            end
            OP_AND: begin
                add_x    = op_a;
                add_y    = op_b;
                pick_gen = 1'b1;
            end
            OP_NOTA: begin
                add_x = ~op_a;
                add_y = ZERO_W;
            end
            OP_SHL: begin
                add_x      = op_b;
                add_y      = op_b;
                chain_cin  = 1'b0;
                kill_carry = 1'b0;
            end
            OP_RSV6, OP_RSV7: begin
                force_zero = 1'b1;
            end
            default: begin
                force_zero = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pg_stage.sv
module pg_stage #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] add_x,
    input  logic [WIDTH-1:0] add_y,
    output logic [WIDTH-1:0] prop,
    output logic [WIDTH-1:0] gen
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign prop[i] = add_x[i] ^ add_y[i];
        assign gen[i]  = add_x[i] & add_y[i];
    end

endmodule

// File: rtl/carry_chain.sv
module carry_chain #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] prop,
    input  logic [WIDTH-1:0] gen,
    input  logic             chain_cin,
    input  logic             kill_carry,
    output logic [WIDTH-1:0] carry_into,
    output logic             chain_cout
);

    logic [WIDTH:0] c;

    assign c[0] = chain_cin & ~kill_carry;

    for (genvar i = 0; i < WIDTH; i++) begin : g_rip
        assign c[i+1] = ~kill_carry & (gen[i] | (prop[i] & c[i]));
    end

    assign carry_into = c[WIDTH-1:0];
    assign chain_cout = c[WIDTH];

endmodule

// File: rtl/sum_select.sv
module sum_select #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] prop,
    input  logic [WIDTH-1:0] gen,
    input  logic [WIDTH-1:0] carry_into,
    input  logic             pick_gen,
    input  logic             force_zero,
    output logic [WIDTH-1:0] sum_out
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        always_comb begin
            if (force_zero)
                sum_out[i] = 1'b0;
            else if (pick_gen)
                sum_out[i] = gen[i];
            else
                sum_out[i] = prop[i] ^ carry_into[i];
        end
    end

endmodule

// File: rtl/shared_chain_alu.sv
module shared_chain_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic [OPW-1:0]   opcode,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);

    alu_op_e          op_sel;
    logic [WIDTH-1:0] add_x;
    logic [WIDTH-1:0] add_y;
    logic             chain_cin;
    logic             kill_carry;
    logic             pick_gen;
    logic             force_zero;
    logic [WIDTH-1:0] prop;
    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] carry_into;
    logic             chain_cout;

    assign op_sel = alu_op_e'(opcode);

    operand_prep #(.WIDTH(WIDTH)) prep_i (
        .op_a       (op_a),
        .op_b       (op_b),
        .carry_in   (carry_in),
        .op         (op_sel),
        .add_x      (add_x),
        .add_y      (add_y),
        .chain_cin  (chain_cin),
        .kill_carry (kill_carry),
        .pick_gen   (pick_gen),
        .force_zero (force_zero)
    );

    pg_stage #(.WIDTH(WIDTH)) pg_i (
        .add_x (add_x),
        .add_y (add_y),
        .prop  (prop),
        .gen   (gen)
    );

    carry_chain #(.WIDTH(WIDTH)) chain_i (
        .prop       (prop),
        .gen        (gen),
        .chain_cin  (chain_cin),
        .kill_carry (kill_carry),
        .carry_into (carry_into),
        .chain_cout (chain_cout)
    );

    sum_select #(.WIDTH(WIDTH)) sel_i (
        .prop       (prop),
        .gen        (gen),
        .carry_into (carry_into),
        .pick_gen   (pick_gen),
        .force_zero (force_zero),
        .sum_out    (result)
    );

    assign carry_out = chain_cout;

endmodule

// File: rtl/shared_chain_alu_chk.sv
module shared_chain_alu_chk
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [OPW-1:0]   opcode,
    input logic [WIDTH-1:0] result,
    input logic             carry_out
);

    localparam logic [WIDTH:0] CIN_PAD = '0;

    logic [WIDTH:0] add_ref;
    assign add_ref = {1'b0, op_a} + {1'b0, op_b} + {CIN_PAD[WIDTH:1], carry_in};

    always_comb begin
        if (opcode == 3'd0) begin
            p_add_sum_r1: assert ({carry_out, result} == add_ref)
                else $error("add mismatch");
        end
        if (opcode == 3'd1) begin
            p_sub_borrow_r2: assert (carry_out == (op_b >= op_a))
                else $error("subtract carry mismatch");
        end
        if (opcode == 3'd2) begin
            p_xor_nocarry_r3: assert (result == (op_a ^ op_b) && !carry_out)
                else $error("xor mismatch");
        end
        if (opcode == 3'd3) begin
            p_and_nocarry_r4: assert (result == (op_a & op_b) && !carry_out)
                else $error("and mismatch");
        end
        if (opcode == 3'd4) begin
            p_not_nocarry_r5: assert (result == ~op_a && !carry_out)
                else $error("complement mismatch");
        end
        if (opcode == 3'd5) begin
            p_shl_lsb_r6: assert (!result[0] && carry_out == op_b[WIDTH-1])
                else $error("shift mismatch");
        end
        if (opcode[2:1] == 2'b11) begin
            p_rsv_zero_r7: assert (result == '0 && !carry_out)
                else $error("reserved code not zero");
        end
    end

endmodule

bind shared_chain_alu shared_chain_alu_chk #(.WIDTH(WIDTH)) chk_i (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .opcode    (opcode),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/shared_chain_alu_tb_top.sv
module shared_chain_alu_tb_top;

    localparam int W = 8;
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic [2:0]   opcode = 3'd0;
    logic [W-1:0] result;
    logic         carry_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shared_chain_alu #(.WIDTH(W)) dut_i (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .opcode    (opcode),
        .result    (result),
        .carry_out (carry_out)
    );

    task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got {cout,res}=%h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [W:0] model(input logic [2:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic ci);
        logic [W:0] r;
        case (op)
            3'd0: r = {1'b0, a} + {1'b0, b} + (W+1)'(ci);
            3'd1: r = {(b >= a), W'(b - a)};
            3'd2: r = {1'b0, a ^ b};
            3'd3: r = {1'b0, a & b};
            3'd4: r = {1'b0, ~a};
            3'd5: r = {b[W-1], b[W-2:0], 1'b0};
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic apply(input string req, input logic [2:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic ci);
        @(posedge clk);
        opcode   = op;
        op_a     = a;
        op_b     = b;
        carry_in = ci;
        @(negedge clk);
        check(req, {carry_out, result}, model(op, a, b, ci));
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check("R1 idle zero inputs", {carry_out, result}, '0);
    endtask

    task automatic t_add();
        apply("R1 add ones+1", 3'd0, ONES, 8'h00, 1'b1);
        apply("R1 add full ripple", 3'd0, ONES, ONES, 1'b1);
        apply("R1 add no carry", 3'd0, 8'h12, 8'h34, 1'b0);
        for (int i = 0; i < 40; i++)
            apply("R1 add random", 3'd0, W'($urandom), W'($urandom), 1'($urandom));
    endtask

    task automatic t_sub();
        apply("R2 sub equal", 3'd1, 8'h5a, 8'h5a, 1'b0);
        apply("R2 sub borrow", 3'd1, 8'h01, 8'h00, 1'b1);
        apply("R2 sub max", 3'd1, 8'h00, ONES, 1'b1);
        for (int i = 0; i < 40; i++)
            apply("R2 sub random", 3'd1, W'($urandom), W'($urandom), 1'($urandom));
    endtask

    task automatic t_xor();
        apply("R3 xor mixed", 3'd2, 8'hf0, 8'h3c, 1'b0);
        for (int i = 0; i < 20; i++)
            apply("R3 xor random", 3'd2, W'($urandom), W'($urandom), 1'($urandom));
    endtask

    task automatic t_and();
        apply("R4 and mixed", 3'd3, 8'hf0, 8'h3c, 1'b0);
        for (int i = 0; i < 20; i++)
            apply("R4 and random", 3'd3, W'($urandom), W'($urandom), 1'($urandom));
    endtask

    task automatic t_nota();
        apply("R5 not zero", 3'd4, 8'h00, ONES, 1'b1);
        for (int i = 0; i < 20; i++)
            apply("R5 not random", 3'd4, W'($urandom), W'($urandom), 1'($urandom));
    endtask

    task automatic t_shl();
        apply("R6 shl top bit", 3'd5, ONES, 8'h81, 1'b1);
        apply("R6 shl no top", 3'd5, 8'h00, 8'h40, 1'b0);
        for (int i = 0; i < 20; i++)
            apply("R6 shl random", 3'd5, W'($urandom), W'($urandom), 1'($urandom));
    endtask

    task automatic t_reserved();
        apply("R7 code6 ones", 3'd6, ONES, ONES, 1'b1);
        apply("R7 code7 ones", 3'd7, ONES, ONES, 1'b1);
        for (int i = 0; i < 10; i++)
            apply("R7 reserved random", 3'(6 + (i % 2)), W'($urandom), W'($urandom), 1'($urandom));
    endtask

    task automatic t_carry_kill();
        apply("R8 xor ones cin1", 3'd2, ONES, ONES, 1'b1);
        apply("R8 and ones cin1", 3'd3, ONES, ONES, 1'b1);
        apply("R8 not ones cin1", 3'd4, ONES, ONES, 1'b1);
        apply("R8 xor alt cin1", 3'd2, 8'h55, 8'h55, 1'b1);
    endtask

    initial begin
        t_reset_state();
        t_add();
        t_sub();
        t_xor();
        t_and();
        t_nota();
        t_shl();
        t_reserved();
        t_carry_kill();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule